// File: doc/BRIEF.md
# Per-Cluster Private Region Decoder

This block sits in front of a 4 KB private peripheral window that is shared by up to four CPUs of one cluster. Each access brings a byte offset, a read strobe, a write strobe, write data and the 2-bit number of the CPU that issued it. The block keeps a small snoop-control register group of its own. It steers every other access either to a per-CPU interrupt-interface port or to one of the per-CPU timer/watchdog register banks. For a steered access it drives a select, a CPU or bank number, a local register offset and the interrupt number of the addressed timer. Read data comes back registered, one cycle after the read.

Two kinds of window exist side by side. An alias window always reaches the resources of the requesting CPU. Indexed windows reach those of the CPU that the page number names. Inside a timer window, one address bit picks the watchdog instead of the timer. If a window names a CPU that the cluster does not have, reads return zero and writes are dropped without an error. Offsets that map to nothing raise a one-cycle error pulse.

Top module: `prv_region_decode`

## Requirements
- R1: Only offset bits [11:0] take part in decoding. An offset that differs from another only above bit 11 behaves in exactly the same way.
- R2: The control register sits at offset 0x000 and resets to 0. A write stores data bit 0 only. A read returns that bit in bit 0 and zeros in every other bit.
- R3: The configuration register at 0x004 reads as (((1<<N)-1)<<4) | (N-1) for N CPUs. Offsets 0x008 and 0x00C read as zero. A write to 0x00C has no effect and raises no error.
- R4: Offsets 0x100..0x1FF assert ifSel for the requesting CPU (ifCpu = reqCpu), with localOff = offset[7:0].
- R5: Offsets 0x200..0x5FF assert ifSel with ifCpu = offset[11:8] - 2 and localOff = offset[7:0].
- R6: Offsets 0x600..0x6FF assert tmrSel for the requesting CPU. Offsets 0x700..0xAFF assert tmrSel for CPU offset[11:8] - 7.
- R7: In a timer window, tmrBank = 2*cpu + offset[5], where bit 5 set selects the watchdog. localOff = offset[3:0] with its upper bits zero. tmrIrqId is 29 for the timer and 30 for the watchdog.
- R8: If the CPU that a window resolves to, by index or by alias, is N or greater, no select is raised, periphRd and periphWr stay low, a read returns zero and accErr stays low.
- R9: An unmapped access raises accErr for exactly the cycle after it, and a read returns zero. Unmapped accesses are offsets 0x000..0x0FF other than 0x000, 0x004, 0x008 and 0x00C, writes to 0x004 or 0x008, and offsets 0xB00 and above.
- R10: rdValid is high in the cycle after every read, and only then. rdData then carries the data of the selected source, sampled in the cycle of the read. After reset, rdValid, rdData and accErr are zero.
- R11: periphRd and periphWr follow the access strobes only while ifSel or tmrSel is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| reqOffset | input | OFF_W | Byte offset of the access |
| reqCpu | input | 2 | Number of the requesting CPU |
| wrData | input | DATA_W | Write data |
| ifSel | output | 1 | Interrupt-interface access |
| ifCpu | output | 2 | CPU whose interface is addressed |
| tmrSel | output | 1 | Timer/watchdog access |
| tmrBank | output | 3 | Timer bank, 2*cpu + watchdog bit |
| tmrIrqId | output | 5 | Interrupt number of the addressed bank |
| localOff | output | 8 | Register offset inside the target |
| periphRd | output | 1 | Read strobe toward the selected target |
| periphWr | output | 1 | Write strobe toward the selected target |
| ifRdData | input | DATA_W | Read data from the interrupt interfaces |
| tmrRdData | input | DATA_W | Read data from the timer banks |
| rdValid | output | 1 | Read data valid |
| rdData | output | DATA_W | Returned read data |
| accErr | output | 1 | One-cycle unmapped-access pulse |

## Verification
A page that decodes wrongly shows at once, in the same cycle, on the select, CPU, bank or local-offset outputs. It can also show one cycle later as a spurious or missing accErr pulse. A wrong alias or CPU-count check puts a select on a CPU that does not exist. It can also leave out data that the read should have returned. A corrupted control bit shows on the next read of offset 0x000. Writes that must have no effect are followed by reads, so their result reaches the read-data port.

// File: rtl/prd_pkg.sv
package prd_pkg;

  localparam int PAGE_W  = 4;
  localparam int CPU_W   = 2;
  localparam int LOC_W   = 8;
  localparam int BANK_W  = CPU_W + 1;
  localparam int IRQ_W   = 5;
  localparam logic [IRQ_W-1:0] TIMER_IRQ = 5'd29;
  localparam logic [IRQ_W-1:0] WDOG_IRQ  = 5'd30;

  typedef enum logic [2:0] {
    T_IDLE,
    T_SCU,
    T_IRQIF,
    T_TIMER,
    T_BLOCKED,
    T_UNMAPPED
  } tgtE;

  typedef struct packed {
    tgtE              tgt;
    logic             rd;
    logic             wr;
    logic [1:0]       scuReg;
    logic [CPU_W-1:0] cpu;
    logic             wdSel;
    logic [LOC_W-1:0] locOff;
  } strobeT;

endpackage

// File: rtl/prd_decode.sv
module prd_decode
  import prd_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int OFF_W   = 32
) (
  input  logic             rdEn,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [CPU_W-1:0] reqCpu,
  output strobeT           strb
);

  localparam logic [CPU_W:0] CPU_LIMIT = (CPU_W+1)'(NUM_CPU);

  logic [11:0]       off12;
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] pageIf;
  logic [PAGE_W-1:0] pageTmr;
  logic              access;

  assign off12   = reqOffset[11:0];
  assign page    = off12[11:8];
  assign pageIf  = page - 4'd2;
  assign pageTmr = page - 4'd7;
  assign access  = rdEn | wrEn;

  always_comb begin
    strb = '0;
    strb.tgt = T_IDLE;
    if (access) begin
      strb.rd = rdEn;
      strb.wr = wrEn;
      if (page == 4'd0) begin
        strb.scuReg = off12[3:2];
        if (off12[7:4] != 4'd0 || off12[1:0] != 2'd0) begin
          strb.tgt = T_UNMAPPED;
        end else if (wrEn && (off12[3:2] == 2'd1 || off12[3:2] == 2'd2)) begin
          strb.tgt = T_UNMAPPED;
        end else begin
          strb.tgt = T_SCU;
        end
      end else if (page == 4'd1) begin
        strb.tgt    = T_IRQIF;
        strb.cpu    = reqCpu;
        strb.locOff = off12[7:0];
      end else if (page <= 4'd5) begin
        strb.tgt    = T_IRQIF;
        strb.cpu    = pageIf[CPU_W-1:0];
        strb.locOff = off12[7:0];
      end else if (page == 4'd6) begin
        strb.tgt    = T_TIMER;
        strb.cpu    = reqCpu;
        strb.wdSel  = off12[5];
        strb.locOff = {4'd0, off12[3:0]};
      end else if (page <= 4'd10) begin
        strb.tgt    = T_TIMER;
        strb.cpu    = pageTmr[CPU_W-1:0];
        strb.wdSel  = off12[5];
        strb.locOff = {4'd0, off12[3:0]};
      end else begin
        strb.tgt = T_UNMAPPED;
      end
      if ((strb.tgt == T_IRQIF || strb.tgt == T_TIMER) &&
          {1'b0, strb.cpu} >= CPU_LIMIT) begin
        strb.tgt = T_BLOCKED;
      end
    end
  end

endmodule

// File: rtl/prd_datapath.sv
module prd_datapath
  import prd_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] ifRdData,
  input  logic [DATA_W-1:0] tmrRdData,
  output logic              ifSel,
  output logic [CPU_W-1:0]  ifCpu,
  output logic              tmrSel,
  output logic [BANK_W-1:0] tmrBank,
  output logic [IRQ_W-1:0]  tmrIrqId,
  output logic [LOC_W-1:0]  localOff,
  output logic              periphRd,
  output logic              periphWr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              accErr
);

  localparam logic [DATA_W-1:0] CFG_WORD =
    DATA_W'((((1 << NUM_CPU) - 1) << 4) | (NUM_CPU - 1));

  logic              scuCtrlQ;
  logic              ctrlWrite;
  logic              routed;
  logic [DATA_W-1:0] readMux;

  assign ifSel    = (strb.tgt == T_IRQIF);
  assign tmrSel   = (strb.tgt == T_TIMER);
  assign routed   = ifSel | tmrSel;
  assign ifCpu    = ifSel  ? strb.cpu : '0;
  assign tmrBank  = tmrSel ? {strb.cpu, strb.wdSel} : '0;
  assign tmrIrqId = tmrSel ? (strb.wdSel ? WDOG_IRQ : TIMER_IRQ) : '0;
  assign localOff = routed ? strb.locOff : '0;
  assign periphRd = routed & strb.rd;
  assign periphWr = routed & strb.wr;

  assign ctrlWrite = (strb.tgt == T_SCU) && strb.wr && (strb.scuReg == 2'd0);

  always_comb begin
    readMux = '0;
    unique case (strb.tgt)
      T_SCU: begin
        if (strb.scuReg == 2'd0)      readMux = {{(DATA_W-1){1'b0}}, scuCtrlQ};
        else if (strb.scuReg == 2'd1) readMux = CFG_WORD;
        else                          readMux = '0;
      end
      T_IRQIF: readMux = ifRdData;
      T_TIMER: readMux = tmrRdData;
      default: readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scuCtrlQ <= 1'b0;
      rdValid  <= 1'b0;
      rdData   <= '0;
      accErr   <= 1'b0;
    end else begin
      if (ctrlWrite) scuCtrlQ <= wrData[0];
      rdValid <= strb.rd;
      rdData  <= strb.rd ? readMux : '0;
      accErr  <= (strb.tgt == T_UNMAPPED);
    end
  end

  // R2: the control bit moves only on a control write
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlWrite) |-> $stable(scuCtrlQ));

  // R2: a control read shows nothing above bit 0
  a_r2_ctrl_narrow: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(strb.tgt == T_SCU && strb.scuReg == 2'd0) |-> rdData[DATA_W-1:1] == '0);

  // R8: no select may name a missing CPU
  a_r8_if_range: assert property (@(posedge clk) disable iff (!rstN)
    ifSel |-> ({1'b0, ifCpu} < (CPU_W+1)'(NUM_CPU)));

  a_r8_tmr_range: assert property (@(posedge clk) disable iff (!rstN)
    tmrSel |-> ({1'b0, tmrBank[BANK_W-1:1]} < (CPU_W+1)'(NUM_CPU)));

  // R8: a blocked read returns zero
  a_r8_blocked_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && $past(strb.tgt == T_BLOCKED) |-> rdData == '0);

  // R9: an error never follows a routed access, and erroring reads give zero
  a_r9_err_unrouted: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> !$past(periphRd || periphWr));

  a_r9_err_zero: assert property (@(posedge clk) disable iff (!rstN)
    accErr && rdValid |-> rdData == '0);

  // R7: interrupt number follows the watchdog bit of the bank
  a_r7_irq_pair: assert property (@(posedge clk) disable iff (!rstN)
    tmrSel |-> (tmrIrqId == (tmrBank[0] ? 5'd30 : 5'd29)));

  // R10: valid only after a read
  a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(strb.rd));

endmodule

// File: rtl/prv_region_decode.sv
module prv_region_decode
  import prd_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int OFF_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic [1:0]        reqCpu,
  input  logic [DATA_W-1:0] wrData,
  output logic              ifSel,
  output logic [1:0]        ifCpu,
  output logic              tmrSel,
  output logic [2:0]        tmrBank,
  output logic [4:0]        tmrIrqId,
  output logic [7:0]        localOff,
  output logic              periphRd,
  output logic              periphWr,
  input  logic [DATA_W-1:0] ifRdData,
  input  logic [DATA_W-1:0] tmrRdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              accErr
);

  strobeT strb;

  prd_decode #(.NUM_CPU(NUM_CPU), .OFF_W(OFF_W)) uDecode (
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .reqOffset (reqOffset),
    .reqCpu    (reqCpu),
    .strb      (strb)
  );

  prd_datapath #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .ifRdData  (ifRdData),
    .tmrRdData (tmrRdData),
    .ifSel     (ifSel),
    .ifCpu     (ifCpu),
    .tmrSel    (tmrSel),
    .tmrBank   (tmrBank),
    .tmrIrqId  (tmrIrqId),
    .localOff  (localOff),
    .periphRd  (periphRd),
    .periphWr  (periphWr),
    .rdValid   (rdValid),
    .rdData    (rdData),
    .accErr    (accErr)
  );

endmodule

// File: tb/tb_prv_region_decode.sv
module tb_prv_region_decode;

  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rstN;
  logic        rdEn, wrEn;
  logic [31:0] reqOffset;
  logic [1:0]  reqCpu;
  logic [31:0] wrData;
  logic        ifSel, tmrSel, periphRd, periphWr, rdValid, accErr;
  logic [1:0]  ifCpu;
  logic [2:0]  tmrBank;
  logic [4:0]  tmrIrqId;
  logic [7:0]  localOff;
  logic [31:0] ifRdData, tmrRdData, rdData;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ifRdData  = 32'hCA00_0000 | {22'd0, ifCpu, localOff};
  assign tmrRdData = 32'h7E00_0000 | {21'd0, tmrBank, localOff};

  prv_region_decode #(.NUM_CPU(NCPU)) dut (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wrEn(wrEn), .reqOffset(reqOffset),
    .reqCpu(reqCpu), .wrData(wrData), .ifSel(ifSel), .ifCpu(ifCpu),
    .tmrSel(tmrSel), .tmrBank(tmrBank), .tmrIrqId(tmrIrqId), .localOff(localOff),
    .periphRd(periphRd), .periphWr(periphWr), .ifRdData(ifRdData),
    .tmrRdData(tmrRdData), .rdValid(rdValid), .rdData(rdData), .accErr(accErr)
  );

  typedef struct {
    bit          v;
    logic [31:0] d;
    bit          e;
    string       tag;
  } itemT;

  itemT sbQ[$];
  int   nVec = 0;
  int   nBad = 0;
  bit   scuM = 1'b0;
  bit   done = 1'b0;

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // kind: 0 none, 1 scu, 2 irq interface, 3 timer, 4 blocked, 5 unmapped
  task automatic access(input bit rd, input bit wr, input logic [31:0] off,
                        input logic [1:0] cpu, input logic [31:0] wd, input string tag);
    logic [11:0] o;
    logic [3:0]  pg;
    int          kind;
    int          c;
    logic [31:0] data;
    bit          expIf, expTm;
    logic [1:0]  expIfCpu;
    logic [2:0]  expBank;
    logic [4:0]  expIrq;
    logic [7:0]  expLoc;
    itemT        it;
    o = off[11:0];
    pg = o[11:8];
    kind = 0; c = 0; data = '0;
    if (pg == 4'd0) begin
      kind = 1;
      if (o == 12'h000) begin
        data = {31'd0, scuM};
      end else if (o == 12'h004) begin
        if (wr) kind = 5;
        else data = 32'((((1 << NCPU) - 1) << 4) | (NCPU - 1));
      end else if (o == 12'h008) begin
        if (wr) kind = 5;
      end else if (o != 12'h00C) begin
        kind = 5;
      end
    end else if (pg == 4'd1) begin kind = 2; c = int'(cpu);
    end else if (pg <= 4'd5) begin kind = 2; c = int'(pg) - 2;
    end else if (pg == 4'd6) begin kind = 3; c = int'(cpu);
    end else if (pg <= 4'd10) begin kind = 3; c = int'(pg) - 7;
    end else kind = 5;
    if ((kind == 2 || kind == 3) && c >= NCPU) kind = 4;
    expIf = (kind == 2); expTm = (kind == 3);
    expIfCpu = expIf ? 2'(c) : 2'd0;
    expBank  = expTm ? 3'(c * 2 + int'(o[5])) : 3'd0;
    expIrq   = expTm ? (o[5] ? 5'd30 : 5'd29) : 5'd0;
    expLoc   = expIf ? o[7:0] : (expTm ? {4'd0, o[3:0]} : 8'd0);
    if (kind == 2) data = 32'hCA00_0000 | {22'd0, expIfCpu, expLoc};
    if (kind == 3) data = 32'h7E00_0000 | {21'd0, expBank, expLoc};
    if (kind >= 4) data = '0;

    @(negedge clk);
    rdEn = rd; wrEn = wr; reqOffset = off; reqCpu = cpu; wrData = wd;
    #1;
    report({ifSel, ifCpu, tmrSel, tmrBank, tmrIrqId, localOff, periphRd, periphWr} ===
           {expIf, expIfCpu, expTm, expBank, expIrq, expLoc,
            (expIf | expTm) & rd, (expIf | expTm) & wr},
           tag, "route",
           64'({ifSel, ifCpu, tmrSel, tmrBank, tmrIrqId, localOff, periphRd, periphWr}),
           64'({expIf, expIfCpu, expTm, expBank, expIrq, expLoc,
                (expIf | expTm) & rd, (expIf | expTm) & wr}));
    it.v = rd; it.d = rd ? data : '0; it.e = (kind == 5); it.tag = tag;
    sbQ.push_back(it);
    if (kind == 1 && wr && o == 12'h000) scuM = wd[0];
  endtask

  task automatic idle();
    itemT it;
    @(negedge clk);
    rdEn = 0; wrEn = 0;
    it.v = 0; it.d = '0; it.e = 0; it.tag = "R10";
    sbQ.push_back(it);
  endtask

  // monitor: compares registered results one edge after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        itemT it;
        it = sbQ.pop_front();
        report(rdValid === it.v, it.tag, "rdValid", 64'(rdValid), 64'(it.v));
        if (it.v) report(rdData === it.d, it.tag, "rdData", 64'(rdData), 64'(it.d));
        report(accErr === it.e, it.tag, "accErr", 64'(accErr), 64'(it.e));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      nVec++; nBad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 0; rdEn = 0; wrEn = 0; reqOffset = '0; reqCpu = '0; wrData = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    report(rdValid === 1'b0 && accErr === 1'b0 && rdData === '0, "R10", "reset",
           64'({rdValid, accErr, rdData}), 64'd0);

    // R3 configuration and zero registers
    access(1, 0, 32'h004, 2'd0, 0, "R3");
    access(1, 0, 32'h008, 2'd1, 0, "R3");
    access(1, 0, 32'h00C, 2'd2, 0, "R3");
    // R2 control register
    access(1, 0, 32'h000, 2'd0, 0, "R2");
    access(0, 1, 32'h000, 2'd0, 32'hFFFF_FFFF, "R2");
    access(1, 0, 32'h000, 2'd0, 0, "R2");
    access(0, 1, 32'h00C, 2'd0, 32'h0, "R3");
    access(1, 0, 32'h000, 2'd1, 0, "R3");
    access(0, 1, 32'h000, 2'd0, 32'hFFFF_FFFE, "R2");
    access(1, 0, 32'h000, 2'd0, 0, "R2");
    // R9 unmapped
    access(0, 1, 32'h004, 2'd0, 32'h1, "R9");
    access(0, 1, 32'h008, 2'd0, 32'h1, "R9");
    access(1, 0, 32'h010, 2'd0, 0, "R9");
    access(1, 0, 32'h002, 2'd0, 0, "R9");
    access(1, 0, 32'hB00, 2'd0, 0, "R9");
    access(0, 1, 32'hFFC, 2'd0, 32'h5, "R9");
    idle();
    access(1, 0, 32'h004, 2'd0, 0, "R3");
    // R4 alias interface window
    access(1, 0, 32'h1A4, 2'd2, 0, "R4");
    access(0, 1, 32'h1FF, 2'd0, 32'h9, "R11");
    access(1, 0, 32'h110, 2'd3, 0, "R8");
    // R5 indexed interface windows
    access(1, 0, 32'h234, 2'd0, 0, "R5");
    access(1, 0, 32'h3C8, 2'd0, 0, "R5");
    access(1, 0, 32'h4F0, 2'd1, 0, "R5");
    access(1, 0, 32'h500, 2'd0, 0, "R8");
    access(0, 1, 32'h5FC, 2'd0, 32'h3, "R8");
    // R6 / R7 timer windows
    access(1, 0, 32'h628, 2'd1, 0, "R7");
    access(1, 0, 32'h60C, 2'd0, 0, "R6");
    access(0, 1, 32'h6E4, 2'd2, 32'h7, "R11");
    access(1, 0, 32'h624, 2'd3, 0, "R8");
    access(1, 0, 32'h704, 2'd0, 0, "R6");
    access(1, 0, 32'h82C, 2'd0, 0, "R7");
    access(1, 0, 32'h924, 2'd0, 0, "R7");
    access(1, 0, 32'hA00, 2'd0, 0, "R8");
    // R1 upper offset bits ignored
    access(1, 0, 32'hABCD_1104, 2'd1, 0, "R1");
    access(1, 0, 32'h1234_5004, 2'd0, 0, "R1");
    access(0, 1, 32'hFFFF_F000, 2'd0, 32'h1, "R1");
    access(1, 0, 32'h8000_0000, 2'd0, 0, "R1");
    access(1, 0, 32'h0000_7B00, 2'd0, 0, "R1");
    // read and write together on a timer bank
    access(1, 1, 32'h620, 2'd0, 32'h1, "R11");
    repeat (3) idle();
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule